// File: doc/BRIEF.md
# Power-Good and Fault Supervisor

This block watches a digitized regulator output and reports whether it is healthy. It takes a reference code, the sensed output code and an overcurrent comparator bit. It derives an undervoltage trip point, an undervoltage release point and an overvoltage limit from the reference, and produces three fault flags and a power-good level. That level is meant to drive an open-drain pin: high means released, low means pulled down.

Every comparator result must be seen on two consecutive clock edges before a flag changes, so a one-sample glitch has no effect. Undervoltage uses hysteresis and only reports. Overvoltage has no hysteresis. Both voltage faults clear by themselves, and power-good comes back once the output is inside both limits again. Overcurrent is sticky: once it is set, only disabling the controller or a power-on reset clears it. Power-good is held low until the sequencer reports that soft-start has finished.

Top module: `pgood_supervisor`

## Requirements
- R1: While `por` is high at a clock edge, all state is cleared: after that edge `pgood`, `uv_flag`, `ov_flag` and `oc_flag` are 0.
- R2: `pgood` is a register. After an edge at which `enable`=1, `por`=0, `ss_done`=1 and none of the three flags is set, `pgood` is 1. Otherwise it is 0 after that edge. In particular it stays 0 while `ss_done` is 0.
- R3: An edge with `enable`=0 clears `pgood`, all three flags and the overcurrent latch.
- R4: The undervoltage condition is set when `sense_code` < floor(`ref_code`*105/128), which is about 82 percent of the reference.
- R5: Once set, the undervoltage condition clears only when `sense_code` > floor(`ref_code`*109/128), which is about 85 percent. Between the two points the previous state holds.
- R6: The overvoltage condition is `sense_code` > `ref_code` + OV_OFFSET. The sum is computed one bit wider, so it never wraps. The condition has no hysteresis.
- R7: Once `oc_flag` is set it stays set, even after `oc_trip` returns to 0, until an edge with `enable`=0 or `por`=1.
- R8: A raw condition changes its flag only when it has had the same value at two consecutive clock edges. The flag changes at the second of those edges, and a condition present at a single edge only is ignored. `oc_flag` follows one edge after the filtered overcurrent condition.
- R9: After an undervoltage or overvoltage event, the flags clear and `pgood` returns to 1 without any other action, once the sensed code is back inside both limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| enable | input | 1 | Controller enable; low means shutdown |
| ss_done | input | 1 | Soft-start finished flag from the sequencer |
| ref_code | input | CODE_W | Reference voltage code |
| sense_code | input | CODE_W | Sensed output voltage code |
| oc_trip | input | 1 | Overcurrent comparator output |
| pgood | output | 1 | Power-good level (1 = released high) |
| uv_flag | output | 1 | Undervoltage flag |
| ov_flag | output | 1 | Overvoltage flag |
| oc_flag | output | 1 | Latched overcurrent flag |

## Verification
A wrong filter or hysteresis state shows at `uv_flag` and `ov_flag` no later than the second edge after the sense code moves. It shows at `pgood` one edge after that. The bench sweeps every sense code against several references, starting both from a healthy output and from a deep undervoltage, so that an off-by-one threshold or a lost hysteresis state appears as a flag mismatch at a known code. A stuck or leaky overcurrent latch shows as `oc_flag` or `pgood` wrong within a few edges of the trip pulse, or of the disable.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    localparam int FRAC_SHIFT  = 7;
    localparam int UV_SET_NUM  = 105;  // ~82 %
    localparam int UV_CLR_NUM  = 109;  // ~85 %
    localparam int NUM_FAULTS  = 3;

    localparam int IDX_UV = 0;
    localparam int IDX_OV = 1;
    localparam int IDX_OC = 2;

    typedef struct packed {
        logic oc;
        logic ov;
        logic uv;
    } fault_vec_t;

    // floor(code * num / 2^FRAC_SHIFT), code up to 16 bits
    function automatic logic [23:0] scale_frac(input logic [15:0] code,
                                               input logic [7:0]  num);
        logic [23:0] prod;
        prod = 24'(code) * 24'(num);
        return prod >> FRAC_SHIFT;
    endfunction

endpackage

// File: rtl/pgs_thresholds.sv
module pgs_thresholds
    import pgs_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int OV_OFFSET = 15
) (
    input  logic [CODE_W-1:0] ref_code,
    output logic [CODE_W-1:0] uv_lo,
    output logic [CODE_W-1:0] uv_hi,
    output logic [CODE_W:0]   ov_lim
);
    localparam int OW = CODE_W + 1;

    always_comb begin
        uv_lo  = CODE_W'(scale_frac(16'(ref_code), 8'(UV_SET_NUM)));
        uv_hi  = CODE_W'(scale_frac(16'(ref_code), 8'(UV_CLR_NUM)));
        ov_lim = OW'(ref_code) + OW'(OV_OFFSET);
    end

    // R5: release point never below trip point
    always_comb begin
        a_r5_hyst_order: assert (uv_hi >= uv_lo);
    end

endmodule

// File: rtl/pgs_deglitch.sv
module pgs_deglitch (
    input  logic clk,
    input  logic clr,
    input  logic raw,
    output logic filt
);
    logic prev_q;
    logic filt_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            prev_q <= 1'b0;
            filt_q <= 1'b0;
        end else begin
            prev_q <= raw;
            if (raw == prev_q)
                filt_q <= raw;
        end
    end

    assign filt = filt_q;

    // R8: a filter change always agrees with the sample it was taken at
    a_r8_two_samples: assert property (@(posedge clk) disable iff (clr)
        (filt_q != $past(filt_q)) |-> (filt_q == $past(raw)));

endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor
    import pgs_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int OV_OFFSET = 15
) (
    input  logic              clk,
    input  logic              por,
    input  logic              enable,
    input  logic              ss_done,
    input  logic [CODE_W-1:0] ref_code,
    input  logic [CODE_W-1:0] sense_code,
    input  logic              oc_trip,
    output logic              pgood,
    output logic              uv_flag,
    output logic              ov_flag,
    output logic              oc_flag
);
    logic                  clr;
    logic [CODE_W-1:0]     uv_lo;
    logic [CODE_W-1:0]     uv_hi;
    logic [CODE_W:0]       ov_lim;
    logic [NUM_FAULTS-1:0] raw_bits;
    logic [NUM_FAULTS-1:0] filt_bits;
    fault_vec_t            flags;
    logic                  oc_lat_q;
    logic                  pgood_q;

    assign clr = por | ~enable;

    pgs_thresholds #(.CODE_W(CODE_W), .OV_OFFSET(OV_OFFSET)) u_thr (
        .ref_code (ref_code),
        .uv_lo    (uv_lo),
        .uv_hi    (uv_hi),
        .ov_lim   (ov_lim)
    );

    // raw comparator conditions; UV picks its threshold from its own state
    always_comb begin
        raw_bits[IDX_UV] = filt_bits[IDX_UV] ? (sense_code <= uv_hi)
                                             : (sense_code <  uv_lo);
        raw_bits[IDX_OV] = {1'b0, sense_code} > ov_lim;
        raw_bits[IDX_OC] = oc_trip;
    end

    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_filt
        pgs_deglitch u_dg (
            .clk  (clk),
            .clr  (clr),
            .raw  (raw_bits[i]),
            .filt (filt_bits[i])
        );
    end

    always_ff @(posedge clk) begin
        if (clr) oc_lat_q <= 1'b0;
        else     oc_lat_q <= oc_lat_q | filt_bits[IDX_OC];
    end

    always_comb begin
        flags.uv = filt_bits[IDX_UV];
        flags.ov = filt_bits[IDX_OV];
        flags.oc = oc_lat_q;
    end

    always_ff @(posedge clk) begin
        if (clr) pgood_q <= 1'b0;
        else     pgood_q <= ss_done & ~(|flags);
    end

    assign pgood   = pgood_q;
    assign uv_flag = flags.uv;
    assign ov_flag = flags.ov;
    assign oc_flag = flags.oc;

    // R1: power-on reset clears the outputs
    a_r1_por_clears: assert property (@(posedge clk)
        por |=> (!pgood && !uv_flag && !ov_flag && !oc_flag));

    // R3: disable clears everything
    a_r3_disable_clears: assert property (@(posedge clk) disable iff (por)
        !enable |=> (!pgood && !uv_flag && !ov_flag && !oc_flag));

    // R2: any fault forces power-good low at the next edge
    a_r2_fault_drops_pgood: assert property (@(posedge clk) disable iff (por)
        (uv_flag || ov_flag || oc_flag) |=> !pgood);

    // R2: no power-good before soft-start is done
    a_r2_needs_ss_done: assert property (@(posedge clk) disable iff (por)
        !ss_done |=> !pgood);

    // R7: overcurrent is sticky while enabled
    a_r7_oc_sticky: assert property (@(posedge clk) disable iff (por)
        (oc_flag && enable) |=> oc_flag);

endmodule

// File: tb/pgood_supervisor_bench.sv
module pgood_supervisor_bench;
    localparam int CODE_W = 8;
    localparam int OV_OFF = 15;

    logic clk = 1'b0;
    logic por, enable, ss_done, oc_trip;
    logic [CODE_W-1:0] ref_code, sense_code;
    logic pgood, uv_flag, ov_flag, oc_flag;

    int total = 0;
    int bad   = 0;
    bit m_uv  = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    pgood_supervisor #(.CODE_W(CODE_W), .OV_OFFSET(OV_OFF)) u_pgood_supervisor (
        .clk(clk), .por(por), .enable(enable), .ss_done(ss_done),
        .ref_code(ref_code), .sense_code(sense_code), .oc_trip(oc_trip),
        .pgood(pgood), .uv_flag(uv_flag), .ov_flag(ov_flag), .oc_flag(oc_flag)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int lo_of(input int r); return (r * 105) / 128; endfunction
    function automatic int hi_of(input int r); return (r * 109) / 128; endfunction

    // drive sense, let it settle, update UV model (R4/R5), check flags and pgood
    task automatic settle_chk(input int r, input int s, input string tag);
        sense_code = CODE_W'(s);
        step(5);
        m_uv = m_uv ? (s <= hi_of(r)) : (s < lo_of(r));
        chk(uv_flag, m_uv, {tag, " R4/R5 uv"});
        chk(ov_flag, s > r + OV_OFF, {tag, " R6 ov"});
        chk(pgood, !m_uv && !(s > r + OV_OFF), {tag, " R9 pgood"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int refs[5] = '{0, 40, 100, 200, 255};
        por = 1'b1; enable = 1'b1; ss_done = 1'b1; oc_trip = 1'b0;
        ref_code = 8'd100; sense_code = 8'd100;
        step(3);
        chk(pgood, 1'b0, "R1 pgood in por");
        chk(uv_flag | ov_flag | oc_flag, 1'b0, "R1 flags in por");

        // R2: soft-start gating
        ss_done = 1'b0; por = 1'b0;
        step(4);
        chk(pgood, 1'b0, "R2 pgood before ss_done");
        ss_done = 1'b1;
        step(1);
        chk(pgood, 1'b1, "R2 pgood one edge after ss_done");

        // R8: latency and glitch rejection
        sense_code = 8'd0;
        step(1);
        chk(uv_flag, 1'b0, "R8 uv not after first edge");
        step(1);
        chk(uv_flag, 1'b1, "R8 uv after second edge");
        step(1);
        chk(pgood, 1'b0, "R2 pgood low one edge after uv");
        sense_code = 8'd100;
        step(5);
        chk(pgood, 1'b1, "R9 recovery");
        m_uv = 1'b0;
        sense_code = 8'd0;
        step(1);
        sense_code = 8'd100;
        for (int k = 0; k < 4; k++) begin
            step(1);
            chk(uv_flag, 1'b0, "R8 single-sample uv ignored");
            chk(pgood, 1'b1, "R8 pgood kept after glitch");
        end

        // threshold sweeps from healthy and from deep undervoltage
        foreach (refs[i]) begin
            ref_code = CODE_W'(refs[i]);
            for (int s = 0; s < 256; s++) begin
                settle_chk(refs[i], refs[i], "base");
                settle_chk(refs[i], s, "from good");
                settle_chk(refs[i], 0, "low");
                settle_chk(refs[i], s, "from uv");
            end
        end

        // R7 / R8: overcurrent
        ref_code = 8'd100; sense_code = 8'd100; m_uv = 1'b0;
        step(5);
        oc_trip = 1'b1; step(1); oc_trip = 1'b0;
        step(4);
        chk(oc_flag, 1'b0, "R8 single-sample oc ignored");
        chk(pgood, 1'b1, "R8 pgood after oc glitch");
        oc_trip = 1'b1; step(2); oc_trip = 1'b0;
        step(3);
        chk(oc_flag, 1'b1, "R7 oc latched");
        chk(pgood, 1'b0, "R2 pgood low on oc");
        step(10);
        chk(oc_flag, 1'b1, "R7 oc sticky after trip removed");

        // R3: disable clears
        enable = 1'b0;
        step(1);
        chk(oc_flag, 1'b0, "R3 oc cleared by disable");
        chk(pgood, 1'b0, "R3 pgood low when disabled");
        enable = 1'b1;
        step(2);
        chk(pgood, 1'b1, "R3 pgood back after re-enable");

        // R1: por clears a latched oc
        oc_trip = 1'b1; step(2); oc_trip = 1'b0;
        step(3);
        chk(oc_flag, 1'b1, "R7 oc latched again");
        por = 1'b1;
        step(1);
        chk(oc_flag, 1'b0, "R1 por clears oc");
        chk(pgood, 1'b0, "R1 por clears pgood");
        por = 1'b0;
        step(2);
        chk(pgood, 1'b1, "R1 pgood after por release");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule